// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C master transfer on top of a separate bit-level bus engine. A caller gives it a target address, which may be 7 or 10 bits wide, a direction, a byte count, and two flags. One flag skips the START and address phase. The other skips the closing STOP. With these flags, a long transfer can be split into pieces that chain together under repeated STARTs. The block builds the address bytes and streams payload bytes through byte-wide valid/ready ports. It issues one bus command at a time to the engine: START, STOP, write byte or read byte.

Each transfer ends with exactly one result code. On any NACK or engine error the sequencer abandons the transfer and clears its record that the bus is held. It then pulses a request to the recovery logic, which releases both lines. Electrical line handling, bit timing and bus-lock recovery belong to the neighbouring units.

Top module: `i2c_txn_seq`

## Requirements
- R1: A request is taken only while `reqReady` is high (idle). `busy` rises in the cycle after acceptance and stays high through the cycle in which `doneValid` pulses. A request presented while busy is ignored.
- R2: A byte count of zero completes with result code 1 (invalid). No bus command is issued and `busHeld` is left unchanged.
- R3: In 7-bit mode the address phase is one write-byte command carrying `{addr[6:0], rd}`. Here `rd` is 1 for a read and 0 for a write.
- R4: In 10-bit mode the address phase is two write-byte commands. The first is `{5'b11110, addr[9:8], rd}` and the second is `addr[7:0]`.
- R5: Without the no-start flag, a START command (`cmdOp`=0) precedes the address phase. With the flag set, the first command is the first data byte.
- R6: A NACK (`rspNack`) on any address byte ends the transfer with result code 2 (no device).
- R7: Read-byte commands (`cmdOp`=3) carry `cmdAck`=1 for every byte except the last one of the transfer, which carries 0.
- R8: Each byte read is presented on `rxData` with `rxValid` and held stable until taken with `rxReady`. Bytes are delivered in bus order.
- R9: Write data is taken from the `tx` port in order and sent as write-byte commands (`cmdOp`=2). A NACK on a data byte ends the transfer with result code 3.
- R10: Without the no-stop flag, a STOP command (`cmdOp`=1) follows the last byte and `busHeld` falls. With the flag, no STOP is issued and `busHeld` keeps its state (high after a START in this transfer).
- R11: An engine error (`rspErr`=1 arbitration lost, 2 timeout) on any command ends the transfer with result code 4 or 5 respectively. Any abort pulses `recover` for one cycle just before `doneValid` and clears `busHeld`.
- R12: A transfer that completes without fault reports result code 0.
- R13: A command stays on `cmdValid`/`cmdOp`/`cmdData` unchanged until the engine answers with `cmdDone`. Only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request strobe |
| reqReady | output | 1 | Sequencer idle, request will be taken |
| reqAddr | input | 10 | Target address (7-bit mode uses bits 6:0) |
| reqTenBit | input | 1 | Use 10-bit addressing |
| reqRead | input | 1 | 1 read, 0 write |
| reqLen | input | LEN_W | Number of payload bytes |
| reqNoStart | input | 1 | Skip START and address phase |
| reqNoStop | input | 1 | Skip closing STOP, keep bus held |
| busy | output | 1 | Transfer in progress |
| doneValid | output | 1 | One-cycle result strobe |
| doneCode | output | 3 | Result: 0 ok, 1 invalid, 2 no device, 3 data NACK, 4 arbitration lost, 5 timeout |
| txValid | input | 1 | Write byte available |
| txReady | output | 1 | Write byte taken this cycle if valid |
| txData | input | 8 | Write byte |
| rxValid | output | 1 | Read byte available |
| rxReady | input | 1 | Read byte taken this cycle if valid |
| rxData | output | 8 | Read byte |
| cmdValid | output | 1 | Command to bus engine pending |
| cmdOp | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmdData | output | 8 | Byte to write |
| cmdAck | output | 1 | For read byte: 1 send ACK, 0 send NACK |
| cmdDone | input | 1 | Engine finished the pending command |
| rspNack | input | 1 | Target NACKed the written byte |
| rspErr | input | 2 | Engine error: 0 none, 1 arbitration lost, 2 timeout |
| rspData | input | 8 | Byte received by a read command |
| recover | output | 1 | Pulse: release lines and run bus recovery |
| busHeld | output | 1 | A START was sent and not yet closed by STOP or abort |

## Verification
The hardest situations to reach from the ports are faults that land on one chosen command deep in a transfer. Examples are a NACK on the second byte of a 10-bit address, or a timeout on the STOP. A related case is a no-start transfer that must inherit the held-bus state of an earlier no-stop transfer. The bench's engine model counts the commands it receives and injects a NACK or an error at an index picked per transfer. Random and directed transfers are chained back to back, so the held-bus state carries across them. The tx and rx ports are stalled at random so that the command hold and data hold rules are exercised.

// File: rtl/i2c_txn_seq_pkg.sv
`timescale 1ns/1ps
package i2c_txn_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } busOpE;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_INVALID   = 3'd1,
    RES_NO_DEVICE = 3'd2,
    RES_DATA_NACK = 3'd3,
    RES_ARB_LOST  = 3'd4,
    RES_TIMEOUT   = 3'd5
  } resultE;

  typedef enum logic [1:0] {
    ENG_OK      = 2'd0,
    ENG_ARB     = 2'd1,
    ENG_TIMEOUT = 2'd2
  } engErrE;

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_BYTE    = 2'd2
  } dataSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadReq;
    logic    loadTx;
    logic    loadRx;
    logic    decCount;
    logic    setStarted;
    logic    clrStarted;
    logic    setErr;
    resultE  errCode;
    dataSelE dataSel;
  } seqStrobeT;

endpackage

// File: rtl/i2c_txn_seq_path.sv
`timescale 1ns/1ps
module i2c_txn_seq_path
  import i2c_txn_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        sb,
  input  logic [9:0]       reqAddr,
  input  logic             reqTenBit,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqNoStop,
  input  logic [7:0]       txData,
  input  logic [7:0]       rspData,
  output logic             reqLenZero,
  output logic             isRead,
  output logic             isTenBit,
  output logic             noStop,
  output logic             lastByte,
  output logic             started,
  output logic [7:0]       cmdData,
  output logic [7:0]       byteOut,
  output resultE           result
);

  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  logic [9:0]       addrQ;
  logic [LEN_W-1:0] remainQ;
  logic [7:0]       byteQ;
  logic [7:0]       addrHi;
  logic [7:0]       addrLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      isTenBit <= 1'b0;
      isRead   <= 1'b0;
      noStop   <= 1'b0;
      remainQ  <= '0;
      byteQ    <= '0;
      started  <= 1'b0;
      result   <= RES_OK;
    end else begin
      if (sb.loadReq) begin
        addrQ    <= reqAddr;
        isTenBit <= reqTenBit;
        isRead   <= reqRead;
        noStop   <= reqNoStop;
        remainQ  <= reqLen;
        result   <= (reqLen == '0) ? RES_INVALID : RES_OK;
      end
      if (sb.loadTx) byteQ <= txData;
      if (sb.loadRx) byteQ <= rspData;
      if (sb.decCount) remainQ <= remainQ - 1'b1;
      if (sb.setStarted) started <= 1'b1;
      else if (sb.clrStarted) started <= 1'b0;
      if (sb.setErr) result <= sb.errCode;
    end
  end

  assign reqLenZero = (reqLen == '0);
  assign lastByte   = (remainQ == {{(LEN_W-1){1'b0}}, 1'b1});
  assign addrHi     = isTenBit ? {TEN_BIT_TAG, addrQ[9:8], isRead} : {addrQ[6:0], isRead};
  assign addrLo     = addrQ[7:0];
  assign byteOut    = byteQ;

  always_comb begin
    case (sb.dataSel)
      SEL_ADDR_HI: cmdData = addrHi;
      SEL_ADDR_LO: cmdData = addrLo;
      default:     cmdData = byteQ;
    endcase
  end

endmodule

// File: rtl/i2c_txn_seq_ctrl.sv
`timescale 1ns/1ps
module i2c_txn_seq_ctrl
  import i2c_txn_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqLenZero,
  input  logic       reqNoStart,
  input  logic       reqRead,
  input  logic       isRead,
  input  logic       isTenBit,
  input  logic       noStop,
  input  logic       lastByte,
  input  logic       txValid,
  input  logic       rxReady,
  input  logic       cmdDone,
  input  logic       rspNack,
  input  logic [1:0] rspErr,
  output seqStrobeT  sb,
  output logic       reqReady,
  output logic       busy,
  output logic       txReady,
  output logic       rxValid,
  output logic       cmdValid,
  output busOpE      cmdOp,
  output logic       cmdAck,
  output logic       recover,
  output logic       doneValid
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR1, S_ADDR2, S_FETCH, S_WRITE,
    S_READ, S_PUSH, S_STOP, S_ABORT, S_DONE
  } stateE;

  stateE  state, nxt;
  logic   engFail;
  resultE failCode;
  stateE  dataEntry;
  stateE  phaseEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign engFail   = (rspErr != ENG_OK);
  assign failCode  = (rspErr == ENG_ARB) ? RES_ARB_LOST : RES_TIMEOUT;
  assign dataEntry = isRead ? S_READ : S_FETCH;
  assign phaseEnd  = noStop ? S_DONE : S_STOP;

  always_comb begin
    nxt        = state;
    sb         = '0;
    sb.errCode = RES_OK;
    sb.dataSel = SEL_BYTE;
    cmdValid   = 1'b0;
    cmdOp      = OP_START;
    cmdAck     = 1'b0;
    txReady    = 1'b0;
    rxValid    = 1'b0;
    recover    = 1'b0;
    doneValid  = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          sb.loadReq = 1'b1;
          if (reqLenZero)      nxt = S_DONE;
          else if (reqNoStart) nxt = reqRead ? S_READ : S_FETCH;
          else                 nxt = S_START;
        end
      end
      S_START: begin
        cmdValid = 1'b1;
        cmdOp    = OP_START;
        if (cmdDone) begin
          if (engFail) begin
            sb.setErr = 1'b1; sb.errCode = failCode; nxt = S_ABORT;
          end else begin
            sb.setStarted = 1'b1; nxt = S_ADDR1;
          end
        end
      end
      S_ADDR1, S_ADDR2: begin
        cmdValid   = 1'b1;
        cmdOp      = OP_WRITE;
        sb.dataSel = (state == S_ADDR1) ? SEL_ADDR_HI : SEL_ADDR_LO;
        if (cmdDone) begin
          if (engFail) begin
            sb.setErr = 1'b1; sb.errCode = failCode; nxt = S_ABORT;
          end else if (rspNack) begin
            sb.setErr = 1'b1; sb.errCode = RES_NO_DEVICE; nxt = S_ABORT;
          end else if (state == S_ADDR1 && isTenBit) begin
            nxt = S_ADDR2;
          end else begin
            nxt = dataEntry;
          end
        end
      end
      S_FETCH: begin
        txReady = 1'b1;
        if (txValid) begin
          sb.loadTx = 1'b1; nxt = S_WRITE;
        end
      end
      S_WRITE: begin
        cmdValid = 1'b1;
        cmdOp    = OP_WRITE;
        if (cmdDone) begin
          if (engFail) begin
            sb.setErr = 1'b1; sb.errCode = failCode; nxt = S_ABORT;
          end else if (rspNack) begin
            sb.setErr = 1'b1; sb.errCode = RES_DATA_NACK; nxt = S_ABORT;
          end else begin
            sb.decCount = 1'b1;
            nxt = lastByte ? phaseEnd : S_FETCH;
          end
        end
      end
      S_READ: begin
        cmdValid = 1'b1;
        cmdOp    = OP_READ;
        cmdAck   = !lastByte;
        if (cmdDone) begin
          if (engFail) begin
            sb.setErr = 1'b1; sb.errCode = failCode; nxt = S_ABORT;
          end else begin
            sb.loadRx = 1'b1; nxt = S_PUSH;
          end
        end
      end
      S_PUSH: begin
        rxValid = 1'b1;
        if (rxReady) begin
          sb.decCount = 1'b1;
          nxt = lastByte ? phaseEnd : S_READ;
        end
      end
      S_STOP: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (cmdDone) begin
          if (engFail) begin
            sb.setErr = 1'b1; sb.errCode = failCode; nxt = S_ABORT;
          end else begin
            sb.clrStarted = 1'b1; nxt = S_DONE;
          end
        end
      end
      S_ABORT: begin
        recover       = 1'b1;
        sb.clrStarted = 1'b1;
        nxt           = S_DONE;
      end
      S_DONE: begin
        doneValid = 1'b1;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);

endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
  import i2c_txn_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [9:0]       reqAddr,
  input  logic             reqTenBit,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqNoStart,
  input  logic             reqNoStop,
  output logic             busy,
  output logic             doneValid,
  output logic [2:0]       doneCode,
  input  logic             txValid,
  output logic             txReady,
  input  logic [7:0]       txData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic [7:0]       rxData,
  output logic             cmdValid,
  output logic [1:0]       cmdOp,
  output logic [7:0]       cmdData,
  output logic             cmdAck,
  input  logic             cmdDone,
  input  logic             rspNack,
  input  logic [1:0]       rspErr,
  input  logic [7:0]       rspData,
  output logic             recover,
  output logic             busHeld
);

  seqStrobeT sb;
  busOpE     opE;
  resultE    resE;
  logic      reqLenZero, isRead, isTenBit, noStop, lastByte;

  i2c_txn_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLenZero(reqLenZero),
    .reqNoStart(reqNoStart), .reqRead(reqRead), .isRead(isRead),
    .isTenBit(isTenBit), .noStop(noStop), .lastByte(lastByte),
    .txValid(txValid), .rxReady(rxReady), .cmdDone(cmdDone),
    .rspNack(rspNack), .rspErr(rspErr), .sb(sb), .reqReady(reqReady),
    .busy(busy), .txReady(txReady), .rxValid(rxValid), .cmdValid(cmdValid),
    .cmdOp(opE), .cmdAck(cmdAck), .recover(recover), .doneValid(doneValid)
  );

  i2c_txn_seq_path #(.LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .sb(sb), .reqAddr(reqAddr), .reqTenBit(reqTenBit),
    .reqRead(reqRead), .reqLen(reqLen), .reqNoStop(reqNoStop),
    .txData(txData), .rspData(rspData), .reqLenZero(reqLenZero),
    .isRead(isRead), .isTenBit(isTenBit), .noStop(noStop),
    .lastByte(lastByte), .started(busHeld), .cmdData(cmdData),
    .byteOut(rxData), .result(resE)
  );

  assign cmdOp    = opE;
  assign doneCode = resE;

endmodule

// File: rtl/i2c_txn_seq_chk.sv
`timescale 1ns/1ps
module i2c_txn_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [LEN_W-1:0] reqLen,
  input logic             busy,
  input logic             doneValid,
  input logic [2:0]       doneCode,
  input logic             rxValid,
  input logic             rxReady,
  input logic [7:0]       rxData,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [7:0]       cmdData,
  input logic             cmdDone,
  input logic [1:0]       rspErr,
  input logic             recover,
  input logic             busHeld
);

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  a_r1_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneValid) |=> busy);

  a_r2_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLen == '0) |=> (doneValid && doneCode == 3'd1 && !cmdValid));

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1 && cmdDone && rspErr == 2'd0) |=> !busHeld);

  a_r11_abort_recover: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneCode >= 3'd2) |-> $past(recover));

  a_r11_recover_clears: assert property (@(posedge clk) disable iff (!rstN)
    recover |=> (!busHeld && doneValid));

  a_r13_cmd_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdData)));

endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqLen(reqLen), .busy(busy), .doneValid(doneValid), .doneCode(doneCode),
  .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData), .cmdDone(cmdDone),
  .rspErr(rspErr), .recover(recover), .busHeld(busHeld)
);

// File: tb/test_i2c_txn_seq.sv
`timescale 1ns/1ps
module test_i2c_txn_seq;

  localparam int LEN_W = 8;
  localparam int MAXC  = 48;
  localparam int BIG   = 1000;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WR = 2'd2, C_RD = 2'd3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic reqValid, reqReady, reqTenBit, reqRead, reqNoStart, reqNoStop;
  logic [9:0] reqAddr;
  logic [LEN_W-1:0] reqLen;
  logic busy, doneValid;
  logic [2:0] doneCode;
  logic txValid, txReady, rxValid, rxReady;
  logic [7:0] txData, rxData;
  logic cmdValid, cmdAck, cmdDone, rspNack, recover, busHeld;
  logic [1:0] cmdOp, rspErr;
  logic [7:0] cmdData, rspData;

  i2c_txn_seq #(.LEN_W(LEN_W)) i_i2c_txn_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqTenBit(reqTenBit), .reqRead(reqRead),
    .reqLen(reqLen), .reqNoStart(reqNoStart), .reqNoStop(reqNoStop),
    .busy(busy), .doneValid(doneValid), .doneCode(doneCode),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData), .cmdAck(cmdAck),
    .cmdDone(cmdDone), .rspNack(rspNack), .rspErr(rspErr), .rspData(rspData),
    .recover(recover), .busHeld(busHeld)
  );

  int nChecks = 0;
  int nFail   = 0;

  // engine model log and fault plan
  int logN;
  logic [1:0] logOp [MAXC];
  logic [7:0] logData [MAXC];
  logic       logAck [MAXC];
  int rxExpN, rxGotN;
  logic [7:0] rxExp [MAXC];
  logic [7:0] rxGot [MAXC];
  logic [7:0] txBuf [16];
  int txIdx;
  int nackAt, errAt;
  logic [1:0] errKind;
  int recovN;
  bit heldModel;

  // expected stream
  int expN;
  logic [1:0] expOp [MAXC];
  logic [7:0] expData [MAXC];
  logic       expAck [MAXC];
  bit         expIsAddr [MAXC];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus engine model
  initial begin
    int waitN;
    int k;
    bit pend;
    cmdDone = 1'b0; rspNack = 1'b0; rspErr = 2'd0; rspData = 8'd0;
    pend = 1'b0; waitN = 0;
    forever begin
      @(negedge clk);
      if (cmdDone) begin
        cmdDone = 1'b0; rspNack = 1'b0; rspErr = 2'd0;
      end
      if (!rstN) pend = 1'b0;
      else if (pend) begin
        if (waitN == 0) begin
          k = logN - 1;
          cmdDone = 1'b1;
          if (k == errAt) rspErr = errKind;
          else if (k == nackAt && logOp[k] == C_WR) rspNack = 1'b1;
          if (logOp[k] == C_RD) begin
            rspData = 8'($urandom);
            if (rspErr == 2'd0 && rxExpN < MAXC) begin
              rxExp[rxExpN] = rspData; rxExpN++;
            end
          end
          pend = 1'b0;
        end else waitN--;
      end else if (cmdValid && logN < MAXC) begin
        logOp[logN] = cmdOp; logData[logN] = cmdData; logAck[logN] = cmdAck;
        logN++;
        pend = 1'b1;
        waitN = int'($urandom % 3);
      end
    end
  end

  // write data source
  initial begin
    txValid = 1'b0; txData = 8'd0; txIdx = 0;
    forever begin
      @(negedge clk);
      if (txValid) begin
        txValid = 1'b0; txIdx++;
      end else if (txReady && ($urandom % 3 != 0)) begin
        txValid = 1'b1; txData = txBuf[txIdx % 16];
      end
    end
  end

  // read data sink
  initial begin
    rxReady = 1'b0; rxGotN = 0;
    forever begin
      @(negedge clk);
      if (rxReady) rxReady = 1'b0;
      else if (rxValid && ($urandom % 3 != 0)) begin
        if (rxGotN < MAXC) rxGot[rxGotN] = rxData;
        rxGotN++;
        rxReady = 1'b1;
      end
    end
  end

  initial begin
    recovN = 0;
    forever begin
      @(negedge clk);
      if (recover) recovN++;
    end
  end

  task automatic addExp(input logic [1:0] op, input logic [7:0] d, input logic a, input bit isA);
    expOp[expN] = op; expData[expN] = d; expAck[expN] = a; expIsAddr[expN] = isA;
    expN++;
  endtask

  task automatic runTxn(input logic [9:0] a, input bit ten, input bit rd, input int len,
                        input bit ns, input bit nsp, input int fNack, input int fErr,
                        input logic [1:0] fKind, input bit poke);
    int k, kE, kN, expCode, expReads, guard, bad;
    bit expHeld;
    bit expRec;
    // arm engine and data
    logN = 0; rxExpN = 0; rxGotN = 0; txIdx = 0; recovN = 0;
    nackAt = fNack; errAt = fErr; errKind = fKind;
    for (int i = 0; i < 16; i++) txBuf[i] = 8'($urandom);
    // expected command stream from R3, R4, R5, R7, R9, R10
    expN = 0;
    if (len > 0) begin
      if (!ns) begin
        addExp(C_START, 8'd0, 1'b0, 1'b0);
        if (ten) begin
          addExp(C_WR, {5'b11110, a[9:8], rd}, 1'b0, 1'b1);
          addExp(C_WR, a[7:0], 1'b0, 1'b1);
        end else addExp(C_WR, {a[6:0], rd}, 1'b0, 1'b1);
      end
      for (int i = 0; i < len; i++) begin
        if (rd) addExp(C_RD, 8'd0, (i < len - 1), 1'b0);
        else    addExp(C_WR, txBuf[i], 1'b0, 1'b0);
      end
      if (!nsp) addExp(C_STOP, 8'd0, 1'b0, 1'b0);
    end
    kE = (fErr >= 0 && fErr < expN) ? fErr : BIG;
    kN = (fNack >= 0 && fNack < expN && expOp[(fNack >= 0 && fNack < MAXC) ? fNack : 0] == C_WR) ? fNack : BIG;
    k = (kE < kN) ? kE : kN;
    expReads = 0;
    if (len == 0) begin
      expCode = 1; expHeld = heldModel; expRec = 1'b0;
    end else if (k < expN) begin
      for (int i = 0; i < k; i++) if (expOp[i] == C_RD) expReads++;
      expN = k + 1;
      expCode = (k == kE) ? ((fKind == 2'd1) ? 4 : 5) : (expIsAddr[k] ? 2 : 3);
      expHeld = 1'b0; expRec = 1'b1;
    end else begin
      for (int i = 0; i < expN; i++) if (expOp[i] == C_RD) expReads++;
      expCode = 0; expRec = 1'b0;
      expHeld = nsp ? (ns ? heldModel : 1'b1) : 1'b0;
    end
    // issue request
    @(negedge clk);
    reqAddr = a; reqTenBit = ten; reqRead = rd; reqLen = LEN_W'(len);
    reqNoStart = ns; reqNoStop = nsp; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1 && reqReady == 1'b0, "R1 busy after accept", busy, 1);
    if (poke && !doneValid) begin
      reqLen = '0; reqValid = 1'b1;   // must be ignored while busy (R1)
      @(negedge clk);
      reqValid = 1'b0;
    end
    guard = 0;
    while (!doneValid && guard < 2000) begin
      @(negedge clk); guard++;
    end
    check(int'(doneCode) == expCode, "R2 R6 R9 R11 R12 result code", doneCode, expCode);
    // command stream
    bad = 0;
    if (logN != expN) bad++;
    for (int i = 0; i < expN && i < logN; i++) begin
      if (logOp[i] != expOp[i]) bad++;
      else if (expOp[i] == C_WR && logData[i] != expData[i]) bad++;
      else if (expOp[i] == C_RD && logAck[i] != expAck[i]) bad++;
    end
    check(bad == 0, "R3 R4 R5 R7 R9 R10 R13 command stream", logN, expN);
    // read data delivery
    bad = (rxGotN != expReads) ? 1 : 0;
    for (int i = 0; i < rxGotN && i < rxExpN && i < MAXC; i++)
      if (rxGot[i] != rxExp[i]) bad++;
    check(bad == 0, "R8 read bytes delivered", rxGotN, expReads);
    check(busHeld == expHeld, "R2 R10 R11 bus held state", busHeld, expHeld);
    check(recovN == (expRec ? 1 : 0), "R6 R11 recover pulse", recovN, expRec ? 1 : 0);
    @(negedge clk);
    check(busy == 1'b0 && reqReady == 1'b1, "R1 idle after result", busy, 0);
    heldModel = expHeld;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2a11));
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqTenBit = 1'b0; reqRead = 1'b0;
    reqLen = '0; reqNoStart = 1'b0; reqNoStop = 1'b0;
    nackAt = -1; errAt = -1; errKind = 2'd0; logN = 0; rxExpN = 0;
    heldModel = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && reqReady == 1'b1 && cmdValid == 1'b0 && busHeld == 1'b0 && doneValid == 1'b0,
          "R1 reset state", busy, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corner cases
    runTxn(10'h050, 1'b0, 1'b0, 2, 1'b0, 1'b0, -1, -1, 2'd0, 1'b0); // R3 write
    runTxn(10'h2A5, 1'b1, 1'b1, 3, 1'b0, 1'b0, -1, -1, 2'd0, 1'b0); // R4 R7 read
    runTxn(10'h03C, 1'b0, 1'b1, 2, 1'b0, 1'b0,  1, -1, 2'd0, 1'b0); // R6 address NACK
    runTxn(10'h011, 1'b0, 1'b0, 0, 1'b0, 1'b0, -1, -1, 2'd0, 1'b0); // R2 zero count
    runTxn(10'h022, 1'b0, 1'b0, 3, 1'b0, 1'b0,  3, -1, 2'd0, 1'b0); // R9 data NACK
    runTxn(10'h033, 1'b0, 1'b0, 2, 1'b0, 1'b1, -1, -1, 2'd0, 1'b0); // R10 held
    runTxn(10'h033, 1'b0, 1'b1, 2, 1'b1, 1'b0, -1, -1, 2'd0, 1'b0); // R5 chained
    runTxn(10'h044, 1'b0, 1'b0, 1, 1'b0, 1'b0, -1,  0, 2'd2, 1'b0); // R11 timeout on START
    runTxn(10'h155, 1'b1, 1'b0, 2, 1'b0, 1'b0,  2, -1, 2'd0, 1'b0); // R6 second 10-bit byte
    runTxn(10'h066, 1'b0, 1'b1, 4, 1'b0, 1'b0, -1,  4, 2'd1, 1'b0); // R11 arb lost on read
    runTxn(10'h077, 1'b0, 1'b0, 4, 1'b0, 1'b0, -1, -1, 2'd0, 1'b1); // R1 ignored request

    // constrained random
    for (int t = 0; t < 40; t++) begin
      int r, idx, fN, fE;
      logic [1:0] kind;
      r = int'($urandom % 10);
      idx = int'($urandom % 8);
      fN = -1; fE = -1; kind = 2'd0;
      if (r >= 6 && r < 8) fN = idx;
      else if (r >= 8) begin
        fE = idx; kind = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
      end
      runTxn(10'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 6),
             ($urandom % 4 == 0), ($urandom % 3 == 0), fN, fE, kind, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule